// File: doc/BRIEF.md
# Multi-Cycle Shared-Memory Processor Datapath

This block is the 32-bit datapath of a processor that runs each instruction over several clock cycles. It has no sequencer of its own. An external controller drives every multiplexer select and every register enable in each cycle. The datapath sends back only the opcode field of the instruction register and the zero flag of the ALU.

A single word-addressed memory holds both instructions and data. Each cycle, an address-select input chooses whether the memory address comes from the program counter or from the registered ALU result. Intermediate values are held in dedicated registers from one cycle to the next: the instruction, the memory data, operand A, operand B and the ALU result. Because of this, one ALU can compute the PC increment, the branch target and the instruction's own operation in different cycles.

The block also has a 32-entry register file, sign extension and shift-by-two of the immediate, and the jump-target concatenation. A preload port writes words into the memory before execution starts.

Top module: `mcd_datapath`

## Requirements
- R1: A synchronous active-low reset clears the program counter to 0 and the instruction register to 0, so `o_pc` and `o_opcode` read 0 after reset.
- R2: When `i_ir_wr`=1, the instruction register loads the memory word at the selected address at the clock edge. When `i_ir_wr`=0 it holds its value. `o_opcode` shows instruction bits [31:26].
- R3: ALU operand A is the PC when `i_srca_sel`=0 and register A when it is 1. Operand B is chosen by `i_srcb_sel`: 00 selects register B, 01 the constant 4, 10 the sign-extended bits [15:0], and 11 that value shifted left by 2. `o_alu_q` takes the ALU result at every clock edge.
- R4: `i_alu_mode` 00 adds and 01 subtracts A−B. Mode 10 decodes bits [5:0] of the instruction: 0x20 add, 0x22 subtract, 0x24 AND, 0x25 OR, and 0x2A signed set-less-than, which gives 1 or 0.
- R5: `o_zero` is combinational and equals 1 exactly when the current ALU result is 0.
- R6: The PC loads when `i_pc_wr`=1, or when `i_pc_wr_cond`=1 and `o_zero`=1. Otherwise it holds. The source is chosen by `i_pc_src`: 00 selects the ALU result, 01 `o_alu_q`, and 10 the jump target {PC[31:28], instruction[25:0], 2'b00}.
- R7: Register A loads from the register selected by instruction bits [25:21], and register B from bits [20:16], at every edge. Register 0 always reads 0, and writes to it are ignored.
- R8: When `i_reg_wr`=1, the register file is written at the edge that ends the cycle. The destination is bits [20:16] when `i_dst_sel`=0 and bits [15:11] when it is 1. The data is `o_alu_q` when `i_wb_sel`=0 and the memory data register when it is 1.
- R9: The memory address is the PC when `i_addr_sel`=0 and `o_alu_q` when it is 1. The word index is address bits [2+:log2(MEM_WORDS)]. `i_mem_wr` writes register B to that word. The memory data register loads the read word at every edge.
- R10: When `i_ld_en`=1, `i_ld_data` is written to memory word `i_ld_addr` at the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| i_addr_sel | input | 1 | Memory address source: 0 selects PC, 1 selects the ALU result register |
| i_mem_wr | input | 1 | Write register B to memory |
| i_ir_wr | input | 1 | Instruction register load enable |
| i_pc_wr | input | 1 | Unconditional PC load |
| i_pc_wr_cond | input | 1 | PC load qualified by the zero flag |
| i_pc_src | input | 2 | PC next-value source |
| i_srca_sel | input | 1 | ALU operand A select |
| i_srcb_sel | input | 2 | ALU operand B select |
| i_alu_mode | input | 2 | ALU operation class |
| i_reg_wr | input | 1 | Register file write enable |
| i_dst_sel | input | 1 | Destination field select |
| i_wb_sel | input | 1 | Write-back data select |
| i_ld_en | input | 1 | Memory preload write enable |
| i_ld_addr | input | 6 | Preload word index |
| i_ld_data | input | 32 | Preload data |
| o_opcode | output | 6 | Instruction bits [31:26] |
| o_zero | output | 1 | ALU result is zero |
| o_pc | output | 32 | Program counter |
| o_alu_q | output | 32 | Registered ALU result |

## Verification
The assertions rely on the controller never raising `i_pc_wr` and `i_pc_wr_cond` in the same cycle. They also rely on `i_pc_src` never taking the unused code 11 while either PC enable is active, and on a preload never coinciding with `i_mem_wr`.

The bench keeps within these limits by building each step from fixed control patterns: fetch, decode, execute, memory and write-back. Only the branch step raises the conditional enable, and preloads happen only in cycles where every other control is low.

Memory slots are reused as the PC advances. To prevent a later preload from overwriting stored data before it is read back, the store/load checks first jump the PC to address 0.

// File: rtl/mcd_pkg.sv
// Shared encodings for the multi-cycle datapath.
// Assumes 32-bit instruction words with 6-bit opcode and function fields.
package mcd_pkg;
    typedef enum logic [1:0] {
        SRCB_REG    = 2'b00,
        SRCB_FOUR   = 2'b01,
        SRCB_IMM    = 2'b10,
        SRCB_IMM_SH = 2'b11
    } srcb_e;

    typedef enum logic [1:0] {
        PCSRC_ALU  = 2'b00,
        PCSRC_ALUQ = 2'b01,
        PCSRC_JUMP = 2'b10,
        PCSRC_RSVD = 2'b11
    } pcsrc_e;

    typedef enum logic [1:0] {
        AMODE_ADD   = 2'b00,
        AMODE_SUB   = 2'b01,
        AMODE_FUNCT = 2'b10,
        AMODE_RSVD  = 2'b11
    } amode_e;

    typedef enum logic [2:0] {
        OP_ADD,
        OP_SUB,
        OP_AND,
        OP_OR,
        OP_SLT
    } aluop_e;

    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;
    localparam logic [5:0] FN_SLT = 6'h2A;
endpackage

// File: rtl/mcd_alu.sv
// Combinational ALU: turns the mode and function field into an operation,
// and flags a zero result. An unknown function code or mode falls back to add.
module mcd_alu
    import mcd_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [1:0]   mode,
    input  logic [5:0]   funct,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] result,
    output logic         zero
);
    aluop_e op;

    // Pick the operation from the mode, using the function field in mode 10.
    always_comb begin
        op = OP_ADD;
        case (amode_e'(mode))
            AMODE_SUB:   op = OP_SUB;
            AMODE_FUNCT: begin
                case (funct)
                    FN_SUB:  op = OP_SUB;
                    FN_AND:  op = OP_AND;
                    FN_OR:   op = OP_OR;
                    FN_SLT:  op = OP_SLT;
                    default: op = OP_ADD;
                endcase
            end
            default:     op = OP_ADD;
        endcase
    end

    // Compute the selected operation.
    always_comb begin
        case (op)
            OP_SUB:  result = a - b;
            OP_AND:  result = a & b;
            OP_OR:   result = a | b;
            OP_SLT:  result = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
            default: result = a + b;
        endcase
    end

    assign zero = (result == '0);
endmodule

// File: rtl/mcd_regfile.sv
// Register file with two asynchronous read ports and one write port.
// Entry 0 reads as zero and ignores writes. The storage is not reset.
module mcd_regfile #(
    parameter int W = 32,
    parameter int N = 32,
    localparam int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr0,
    input  logic [AW-1:0] raddr1,
    output logic [W-1:0]  rdata0,
    output logic [W-1:0]  rdata1
);
    logic [W-1:0] regs [N];

    // Write at the edge that ends the cycle; entry 0 is never written.
    always_ff @(posedge clk) begin
        if (we && (waddr != '0)) regs[waddr] <= wdata;
    end

    assign rdata0 = (raddr0 == '0) ? '0 : regs[raddr0];
    assign rdata1 = (raddr1 == '0) ? '0 : regs[raddr1];
endmodule

// File: rtl/mcd_mem.sv
// Behavioural word memory shared by instruction fetch and data access.
// Reads are asynchronous. A byte address is reduced to a word index, which
// wraps modulo WORDS.
module mcd_mem #(
    parameter int W = 32,
    parameter int WORDS = 64,
    localparam int MAW = $clog2(WORDS)
) (
    input  logic           clk,
    input  logic           we,
    input  logic [MAW-1:0] widx,
    input  logic [W-1:0]   wdata,
    input  logic [W-1:0]   raddr,
    output logic [W-1:0]   rdata
);
    logic [W-1:0]   mem [WORDS];
    logic [MAW-1:0] ridx;

    assign ridx  = MAW'(raddr >> 2);
    assign rdata = mem[ridx];

    // Store one word at the edge.
    always_ff @(posedge clk) begin
        if (we) mem[widx] <= wdata;
    end
endmodule

// File: rtl/mcd_datapath.sv
// Multi-cycle datapath top: state registers, source multiplexers, the
// shared memory, the register file and the ALU. Every select and enable
// comes from an external controller. The controller is assumed never to
// assert both PC enables together.
module mcd_datapath
    import mcd_pkg::*;
#(
    parameter int XLEN      = 32,
    parameter int MEM_WORDS = 64,
    parameter int NREGS     = 32,
    localparam int MAW      = $clog2(MEM_WORDS),
    localparam int RAW      = $clog2(NREGS),
    localparam int RS_LSB   = 21,
    localparam int RT_LSB   = 16,
    localparam int RD_LSB   = 11,
    localparam int IMM_W    = 16,
    localparam int TGT_W    = 26,
    localparam int OPC_LSB  = 26
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            i_addr_sel,
    input  logic            i_mem_wr,
    input  logic            i_ir_wr,
    input  logic            i_pc_wr,
    input  logic            i_pc_wr_cond,
    input  logic [1:0]      i_pc_src,
    input  logic            i_srca_sel,
    input  logic [1:0]      i_srcb_sel,
    input  logic [1:0]      i_alu_mode,
    input  logic            i_reg_wr,
    input  logic            i_dst_sel,
    input  logic            i_wb_sel,
    input  logic            i_ld_en,
    input  logic [MAW-1:0]  i_ld_addr,
    input  logic [XLEN-1:0] i_ld_data,
    output logic [5:0]      o_opcode,
    output logic            o_zero,
    output logic [XLEN-1:0] o_pc,
    output logic [XLEN-1:0] o_alu_q
);
    logic [XLEN-1:0] pc_q, ir_q, mdr_q, a_q, b_q, alu_q;
    logic [XLEN-1:0] mem_addr, mem_rdata;
    logic [XLEN-1:0] rf_rd0, rf_rd1, rf_wdata;
    logic [RAW-1:0]  rf_waddr;
    logic [XLEN-1:0] imm_ext, imm_sh, opa, opb, alu_res, jump_tgt, pc_next;
    logic            alu_zero, pc_load, mem_we;
    logic [MAW-1:0]  mem_widx;

    // Address and write-port steering for the shared memory.
    assign mem_addr = i_addr_sel ? alu_q : pc_q;
    assign mem_we   = i_ld_en | i_mem_wr;
    assign mem_widx = i_ld_en ? i_ld_addr : MAW'(mem_addr >> 2);

    mcd_mem #(.W(XLEN), .WORDS(MEM_WORDS)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .widx  (mem_widx),
        .wdata (i_ld_en ? i_ld_data : b_q),
        .raddr (mem_addr),
        .rdata (mem_rdata)
    );

    // Register file write steering.
    assign rf_waddr = i_dst_sel ? ir_q[RD_LSB +: RAW] : ir_q[RT_LSB +: RAW];
    assign rf_wdata = i_wb_sel ? mdr_q : alu_q;

    mcd_regfile #(.W(XLEN), .N(NREGS)) u_rf (
        .clk    (clk),
        .we     (i_reg_wr),
        .waddr  (rf_waddr),
        .wdata  (rf_wdata),
        .raddr0 (ir_q[RS_LSB +: RAW]),
        .raddr1 (ir_q[RT_LSB +: RAW]),
        .rdata0 (rf_rd0),
        .rdata1 (rf_rd1)
    );

    // Immediate forms.
    assign imm_ext = {{(XLEN-IMM_W){ir_q[IMM_W-1]}}, ir_q[IMM_W-1:0]};
    assign imm_sh  = imm_ext << 2;

    // ALU operand selection.
    assign opa = i_srca_sel ? a_q : pc_q;
    always_comb begin
        case (srcb_e'(i_srcb_sel))
            SRCB_FOUR:   opb = XLEN'(4);
            SRCB_IMM:    opb = imm_ext;
            SRCB_IMM_SH: opb = imm_sh;
            default:     opb = b_q;
        endcase
    end

    mcd_alu #(.W(XLEN)) u_alu (
        .mode   (i_alu_mode),
        .funct  (ir_q[5:0]),
        .a      (opa),
        .b      (opb),
        .result (alu_res),
        .zero   (alu_zero)
    );

    // Next PC selection and load condition.
    assign jump_tgt = {pc_q[XLEN-1 -: 4], ir_q[TGT_W-1:0], 2'b00};
    always_comb begin
        case (pcsrc_e'(i_pc_src))
            PCSRC_ALUQ: pc_next = alu_q;
            PCSRC_JUMP: pc_next = jump_tgt;
            default:    pc_next = alu_res;
        endcase
    end
    assign pc_load = i_pc_wr | (i_pc_wr_cond & alu_zero);

    // Program counter and instruction register, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= '0;
            ir_q <= '0;
        end else begin
            if (pc_load) pc_q <= pc_next;
            if (i_ir_wr) ir_q <= mem_rdata;
        end
    end

    // Holding registers that load every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mdr_q <= '0;
            a_q   <= '0;
            b_q   <= '0;
            alu_q <= '0;
        end else begin
            mdr_q <= mem_rdata;
            a_q   <= rf_rd0;
            b_q   <= rf_rd1;
            alu_q <= alu_res;
        end
    end

    assign o_opcode = ir_q[XLEN-1:OPC_LSB];
    assign o_zero   = alu_zero;
    assign o_pc     = pc_q;
    assign o_alu_q  = alu_q;
endmodule

// File: rtl/mcd_datapath_chk.sv
// Temporal checks on the datapath's PC and instruction register.
// Assumes the controller never asserts both PC enables together.
module mcd_datapath_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        pc_wr,
    input logic        pc_wr_cond,
    input logic [1:0]  pc_src,
    input logic        ir_wr,
    input logic        srca_sel,
    input logic [1:0]  srcb_sel,
    input logic [1:0]  alu_mode,
    input logic        zero,
    input logic [31:0] pc,
    input logic [31:0] alu_q,
    input logic [5:0]  opcode,
    input logic [25:0] ir_tgt
);
    AST_PC_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !$past(rst_n)) |-> (pc == '0));                        // R1
    AST_IR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !ir_wr |=> $stable(opcode));                                     // R2
    AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!pc_wr && !(pc_wr_cond && zero)) |=> $stable(pc));              // R6
    AST_FETCH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_wr && pc_src == 2'b00 && !srca_sel && srcb_sel == 2'b01 && alu_mode == 2'b00)
        |=> (pc == $past(pc) + 32'd4));                                  // R6
    AST_BRANCH_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!pc_wr && pc_wr_cond && zero && pc_src == 2'b01)
        |=> (pc == $past(alu_q)));                                       // R6
    AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_wr && pc_src == 2'b10)
        |=> (pc == {$past(pc[31:28]), $past(ir_tgt), 2'b00}));           // R6
endmodule

bind mcd_datapath mcd_datapath_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pc_wr      (i_pc_wr),
    .pc_wr_cond (i_pc_wr_cond),
    .pc_src     (i_pc_src),
    .ir_wr      (i_ir_wr),
    .srca_sel   (i_srca_sel),
    .srcb_sel   (i_srcb_sel),
    .alu_mode   (i_alu_mode),
    .zero       (o_zero),
    .pc         (o_pc),
    .alu_q      (o_alu_q),
    .opcode     (o_opcode),
    .ir_tgt     (ir_q[25:0])
);

// File: tb/mcd_datapath_test.sv
// Bench: acts as the controller, driving fixed cycle patterns, and checks
// registered results against values computed from the requirements.
module mcd_datapath_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        i_addr_sel, i_mem_wr, i_ir_wr, i_pc_wr, i_pc_wr_cond;
    logic [1:0]  i_pc_src, i_srcb_sel, i_alu_mode;
    logic        i_srca_sel, i_reg_wr, i_dst_sel, i_wb_sel, i_ld_en;
    logic [5:0]  i_ld_addr;
    logic [31:0] i_ld_data;
    logic [5:0]  o_opcode;
    logic        o_zero;
    logic [31:0] o_pc, o_alu_q;

    int n_chk  = 0;
    int n_fail = 0;

    mcd_datapath uut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    // Record one check; print a FAIL line when it does not match.
    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic ctl_clear();
        {i_addr_sel, i_mem_wr, i_ir_wr, i_pc_wr, i_pc_wr_cond} = '0;
        {i_pc_src, i_srcb_sel, i_alu_mode} = '0;
        {i_srca_sel, i_reg_wr, i_dst_sel, i_wb_sel, i_ld_en} = '0;
        i_ld_addr = '0;
        i_ld_data = '0;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        ctl_clear();
    endtask

    function automatic logic [31:0] sx(input logic [15:0] v);
        return {{16{v[15]}}, v};
    endfunction

    function automatic logic [31:0] ref_op(input logic [5:0] fn, input logic [31:0] a, input logic [31:0] b);
        case (fn)
            6'h22:   return a - b;
            6'h24:   return a & b;
            6'h25:   return a | b;
            6'h2A:   return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
            default: return a + b;
        endcase
    endfunction

    // Preload the word at the PC's slot, then fetch it and decode it.
    task automatic run(input logic [31:0] w);
        i_ld_en = 1'b1; i_ld_addr = o_pc[7:2]; i_ld_data = w;
        tick();
        i_ir_wr = 1'b1; i_srcb_sel = 2'b01; i_pc_wr = 1'b1;
        tick();
        i_srcb_sel = 2'b11;
        tick();
    endtask

    task automatic set_reg(input logic [4:0] r, input logic [15:0] imm);
        run({6'h08, 5'd0, r, imm});
        i_srca_sel = 1'b1; i_srcb_sel = 2'b10;
        tick();
        i_reg_wr = 1'b1;
        tick();
    endtask

    task automatic read_reg(input logic [4:0] r, output logic [31:0] v);
        run({6'h00, r, 5'd0, 5'd0, 5'd0, 6'h20});
        i_srca_sel = 1'b1;
        tick();
        v = o_alu_q;
    endtask

    logic [15:0] vals [8] = '{16'h0000, 16'h0001, 16'hFFFF, 16'h0005,
                              16'h7FFF, 16'h8000, 16'h1234, 16'hFFF9};
    logic [5:0]  fns  [5] = '{6'h20, 6'h22, 6'h24, 6'h25, 6'h2A};

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog actual=%08h expected=%08h", 32'd0, 32'd1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v, p, e;
        ctl_clear();
        rst_n = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
        check("R1 pc after reset", o_pc, 32'd0);
        check("R1 opcode after reset", {26'd0, o_opcode}, 32'd0);

        // R10/R2: preload a word, fetch it, and check the PC step.
        i_ld_en = 1'b1; i_ld_addr = 6'd0; i_ld_data = {6'h2B, 10'd0, 16'hFFFE};
        tick();
        i_ir_wr = 1'b1; i_srcb_sel = 2'b01; i_pc_wr = 1'b1;
        tick();
        check("R10 R2 fetched opcode", {26'd0, o_opcode}, 32'h2B);
        check("R6 pc plus four", o_pc, 32'd4);
        i_srcb_sel = 2'b11;
        tick();
        check("R3 branch target offset", o_alu_q, 32'd4 + (sx(16'hFFFE) << 2));

        // R2: the IR holds while its enable is low.
        i_ld_en = 1'b1; i_ld_addr = 6'd1; i_ld_data = {6'h23, 26'd0};
        tick();
        tick();
        check("R2 IR holds", {26'd0, o_opcode}, 32'h2B);
        i_ir_wr = 1'b1; i_srcb_sel = 2'b01; i_pc_wr = 1'b1;
        tick();
        check("R2 IR loads", {26'd0, o_opcode}, 32'h23);

        // R7: register 0 reads zero after an attempted write.
        set_reg(5'd0, 16'h0055);
        read_reg(5'd0, v);
        check("R7 r0 zero", v, 32'd0);

        // R3/R8: immediate writes to rt, read back through port A.
        for (int i = 0; i < 8; i++) set_reg(5'(i + 1), vals[i]);
        for (int i = 0; i < 8; i++) begin
            read_reg(5'(i + 1), v);
            check("R8 R3 imm write to rt", v, sx(vals[i]));
        end

        // R4/R5/R8: sweep the function codes over all operand pairs.
        for (int i = 0; i < 8; i++) begin
            for (int j = 0; j < 8; j++) begin
                for (int f = 0; f < 5; f++) begin
                    e = ref_op(fns[f], sx(vals[i]), sx(vals[j]));
                    run({6'h00, 5'(i + 1), 5'(j + 1), 5'd9, 5'd0, fns[f]});
                    i_srca_sel = 1'b1; i_alu_mode = 2'b10;
                    #2;
                    check("R5 zero flag", {31'd0, o_zero}, {31'd0, (e == 32'd0)});
                    tick();
                    check("R4 funct result", o_alu_q, e);
                    if (fns[f] == 6'h25 && j == 7) begin
                        i_reg_wr = 1'b1; i_dst_sel = 1'b1;
                        tick();
                        read_reg(5'd9, v);
                        check("R8 rd write back", v, e);
                    end
                end
                run({6'h04, 5'(i + 1), 5'(j + 1), 16'd0});
                i_srca_sel = 1'b1; i_alu_mode = 2'b01;
                tick();
                check("R4 subtract mode", o_alu_q, sx(vals[i]) - sx(vals[j]));
            end
        end

        // R9: store then load after jumping to address 0.
        set_reg(5'd10, 16'h00A0);
        set_reg(5'd11, 16'h8765);
        run({6'h02, 26'd0});
        i_pc_wr = 1'b1; i_pc_src = 2'b10;
        tick();
        check("R6 jump to zero", o_pc, 32'd0);
        run({6'h2B, 5'd10, 5'd11, 16'h0008});
        i_srca_sel = 1'b1; i_srcb_sel = 2'b10;
        tick();
        check("R3 effective address", o_alu_q, 32'h000000A8);
        i_addr_sel = 1'b1; i_mem_wr = 1'b1;
        tick();
        run({6'h23, 5'd10, 5'd12, 16'h0008});
        i_srca_sel = 1'b1; i_srcb_sel = 2'b10;
        tick();
        i_addr_sel = 1'b1;
        tick();
        i_reg_wr = 1'b1; i_wb_sel = 1'b1;
        tick();
        read_reg(5'd12, v);
        check("R9 store load round trip", v, 32'hFFFF8765);

        // R6/R5: taken and untaken conditional branches.
        run({6'h04, 5'd3, 5'd3, 16'h0003});
        p = o_pc;
        i_srca_sel = 1'b1; i_alu_mode = 2'b01; i_pc_src = 2'b01; i_pc_wr_cond = 1'b1;
        #2;
        check("R5 zero on equal", {31'd0, o_zero}, 32'd1);
        tick();
        check("R6 branch taken", o_pc, p + 32'd12);
        run({6'h04, 5'd2, 5'd3, 16'h0003});
        p = o_pc;
        i_srca_sel = 1'b1; i_alu_mode = 2'b01; i_pc_src = 2'b01; i_pc_wr_cond = 1'b1;
        tick();
        check("R6 branch not taken", o_pc, p);

        // R6: a backward branch wraps into high addresses; the jump keeps PC[31:28].
        run({6'h04, 5'd1, 5'd1, 16'h8000});
        p = o_pc;
        i_srca_sel = 1'b1; i_alu_mode = 2'b01; i_pc_src = 2'b01; i_pc_wr_cond = 1'b1;
        tick();
        check("R6 backward branch", o_pc, p + (sx(16'h8000) << 2));
        run({6'h02, 26'h0000010});
        i_pc_wr = 1'b1; i_pc_src = 2'b10;
        tick();
        check("R6 jump keeps upper nibble", o_pc, 32'hF0000040);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule